// File: doc/BRIEF.md
# Integer ALU with immediate forms

This block is the integer execute stage of a 32-bit RISC pipeline. Each cycle that `valid_in` is high it takes an operation code, two register operands, a 16-bit immediate, a 5-bit immediate and a destination register index. It computes one result and registers it together with a write strobe for a 32-entry register file. The outputs appear one clock later.

The operation set covers the following:

- add, subtract, and, or, xor and nor;
- six compares that return 0 or 1;
- arithmetic right, logical right and left shifts, plus left and right rotates;
- a low multiply, and a high multiply in three signedness variants.

Many operations also have an immediate form. The immediate form takes its second operand from the 16-bit immediate, widened in one of three ways, or from the 5-bit shift immediate. Register zero is hard-wired to zero, so a result aimed at index 0 never produces a write strobe.

Top module: `alu_exec`

## Requirements
- R1: Register-register add, subtract, and, or, xor and nor return the 32-bit result of that operation on `a` and `b`. Opcodes are the values of `alu_pkg::alu_op_e`: 0 to 20 are register forms and 21 to 38 are immediate forms.
- R2: The compares greater-or-equal, less-than, not-equal and equal (signed), and greater-or-equal-unsigned and less-than-unsigned, return exactly 1 when the condition holds and 0 otherwise. They do this in both register and immediate forms.
- R3: The 16-bit immediate is widened according to the operation.
  - Add-immediate, multiply-immediate and the four signed immediate compares sign-extend it.
  - And/or/xor-immediate and the two unsigned immediate compares zero-extend it.
  - The high-half and/or/xor forms place it in bits 31:16 with zeros in bits 15:0.
- R4: Register-specified shifts and rotates use only `b[4:0]` as the amount.
- R5: The immediate shifts (arithmetic right, logical right, left, rotate left) take their amount from `imm5`. The `b` input has no effect on them, and there is no immediate rotate right.
- R6: The low multiply and multiply-immediate return bits 31:0 of the product.
- R7: The high multiplies return bits 63:32 of the 64-bit product, for signed×signed, unsigned×unsigned and signed `a` × unsigned `b`.
- R8: `wr_en` is high exactly in the cycle after an accepted input whose `dest` is non-zero. A destination of 0 never writes.
- R9: `valid_out` follows `valid_in` by one cycle. `result` holds its value in cycles where no input is accepted.
- R10: While `rst_n` is low, `valid_out`, `wr_en` and `result` are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, already synchronised to clk |
| valid_in | input | 1 | Operation present this cycle |
| op | input | 6 | Operation code (`alu_op_e`) |
| a | input | 32 | First register operand |
| b | input | 32 | Second register operand |
| imm16 | input | 16 | 16-bit immediate |
| imm5 | input | 5 | Shift-amount immediate |
| dest | input | 5 | Destination register index |
| valid_out | output | 1 | Registered result valid |
| result | output | 32 | Registered result |
| wr_en | output | 1 | Register-file write strobe |

## Verification
Every opcode is swept against eight first operands and eight second-operand/immediate pairs.

- The sign-boundary operands (0x7FFFFFFF, 0x80000000, all ones) separate signed from unsigned compares and the three high-multiply variants.
- Immediates with bit 15 set (0x8000, 0xFFFF, 0xF00F) separate sign extension, zero extension and upper-half placement.
- Register shift amounts carry junk above bit 4, such as 0xFFFFFFE0 and 0x25, to expose a missing mask. The immediate shifts get a `b` unrelated to `imm5`.
- The destination index cycles through all 32 values, so index 0 is hit repeatedly. Idle cycles between bursts confirm that the result holds.

// File: rtl/alu_pkg.sv
package alu_pkg;

  localparam int OP_W     = 6;
  localparam int OP_COUNT = 39;

  // Register forms 0..20, immediate forms 21..38.
  typedef enum logic [OP_W-1:0] {
    OP_ADD    = 6'd0,  OP_SUB    = 6'd1,  OP_AND    = 6'd2,  OP_OR     = 6'd3,
    OP_XOR    = 6'd4,  OP_NOR    = 6'd5,  OP_CMPGE  = 6'd6,  OP_CMPLT  = 6'd7,
    OP_CMPNE  = 6'd8,  OP_CMPEQ  = 6'd9,  OP_CMPGEU = 6'd10, OP_CMPLTU = 6'd11,
    OP_SRA    = 6'd12, OP_SRL    = 6'd13, OP_SLL    = 6'd14, OP_ROL    = 6'd15,
    OP_ROR    = 6'd16, OP_MUL    = 6'd17, OP_MULHSS = 6'd18, OP_MULHUU = 6'd19,
    OP_MULHSU = 6'd20,
    OP_ADDI   = 6'd21, OP_MULI   = 6'd22, OP_ANDI   = 6'd23, OP_ORI    = 6'd24,
    OP_XORI   = 6'd25, OP_ANDHI  = 6'd26, OP_ORHI   = 6'd27, OP_XORHI  = 6'd28,
    OP_CMPGEI = 6'd29, OP_CMPLTI = 6'd30, OP_CMPNEI = 6'd31, OP_CMPEQI = 6'd32,
    OP_CMPGEUI= 6'd33, OP_CMPLTUI= 6'd34, OP_SRAI   = 6'd35, OP_SRLI   = 6'd36,
    OP_SLLI   = 6'd37, OP_ROLI   = 6'd38
  } alu_op_e;

  typedef enum logic [4:0] {
    F_ADD, F_SUB, F_AND, F_OR, F_XOR, F_NOR,
    F_GE, F_LT, F_NE, F_EQ, F_GEU, F_LTU,
    F_SRA, F_SRL, F_SLL, F_ROL, F_ROR,
    F_MUL, F_MHSS, F_MHUU, F_MHSU
  } func_e;

  typedef enum logic [1:0] { SRC_REG, SRC_IMM16, SRC_IMM5 } bsrc_e;
  typedef enum logic [1:0] { EXT_SIGN, EXT_ZERO, EXT_HIGH } ext_e;

  typedef struct packed {
    func_e func;
    bsrc_e bsrc;
    ext_e  ext;
  } dec_t;

endpackage

// File: rtl/alu_opdec.sv
module alu_opdec
  import alu_pkg::*;
(
  input  logic [OP_W-1:0] op_i,
  output dec_t            dec_o
);

  always_comb begin
    dec_o.bsrc = SRC_REG;
    dec_o.ext  = EXT_SIGN;
    dec_o.func = F_ADD;
    unique case (op_i)
      OP_ADD:     dec_o.func = F_ADD;
      OP_SUB:     dec_o.func = F_SUB;
      OP_AND:     dec_o.func = F_AND;
      OP_OR:      dec_o.func = F_OR;
      OP_XOR:     dec_o.func = F_XOR;
      OP_NOR:     dec_o.func = F_NOR;
      OP_CMPGE:   dec_o.func = F_GE;
      OP_CMPLT:   dec_o.func = F_LT;
      OP_CMPNE:   dec_o.func = F_NE;
      OP_CMPEQ:   dec_o.func = F_EQ;
      OP_CMPGEU:  dec_o.func = F_GEU;
      OP_CMPLTU:  dec_o.func = F_LTU;
      OP_SRA:     dec_o.func = F_SRA;
      OP_SRL:     dec_o.func = F_SRL;
      OP_SLL:     dec_o.func = F_SLL;
      OP_ROL:     dec_o.func = F_ROL;
      OP_ROR:     dec_o.func = F_ROR;
      OP_MUL:     dec_o.func = F_MUL;
      OP_MULHSS:  dec_o.func = F_MHSS;
      OP_MULHUU:  dec_o.func = F_MHUU;
      OP_MULHSU:  dec_o.func = F_MHSU;
      OP_ADDI:    begin dec_o.func = F_ADD; dec_o.bsrc = SRC_IMM16; end
      OP_MULI:    begin dec_o.func = F_MUL; dec_o.bsrc = SRC_IMM16; end
      OP_ANDI:    begin dec_o.func = F_AND; dec_o.bsrc = SRC_IMM16; dec_o.ext = EXT_ZERO; end
      OP_ORI:     begin dec_o.func = F_OR;  dec_o.bsrc = SRC_IMM16; dec_o.ext = EXT_ZERO; end
      OP_XORI:    begin dec_o.func = F_XOR; dec_o.bsrc = SRC_IMM16; dec_o.ext = EXT_ZERO; end
      OP_ANDHI:   begin dec_o.func = F_AND; dec_o.bsrc = SRC_IMM16; dec_o.ext = EXT_HIGH; end
      OP_ORHI:    begin dec_o.func = F_OR;  dec_o.bsrc = SRC_IMM16; dec_o.ext = EXT_HIGH; end
      OP_XORHI:   begin dec_o.func = F_XOR; dec_o.bsrc = SRC_IMM16; dec_o.ext = EXT_HIGH; end
      OP_CMPGEI:  begin dec_o.func = F_GE;  dec_o.bsrc = SRC_IMM16; end
      OP_CMPLTI:  begin dec_o.func = F_LT;  dec_o.bsrc = SRC_IMM16; end
      OP_CMPNEI:  begin dec_o.func = F_NE;  dec_o.bsrc = SRC_IMM16; end
      OP_CMPEQI:  begin dec_o.func = F_EQ;  dec_o.bsrc = SRC_IMM16; end
      OP_CMPGEUI: begin dec_o.func = F_GEU; dec_o.bsrc = SRC_IMM16; dec_o.ext = EXT_ZERO; end
      OP_CMPLTUI: begin dec_o.func = F_LTU; dec_o.bsrc = SRC_IMM16; dec_o.ext = EXT_ZERO; end
      OP_SRAI:    begin dec_o.func = F_SRA; dec_o.bsrc = SRC_IMM5; end
      OP_SRLI:    begin dec_o.func = F_SRL; dec_o.bsrc = SRC_IMM5; end
      OP_SLLI:    begin dec_o.func = F_SLL; dec_o.bsrc = SRC_IMM5; end
      OP_ROLI:    begin dec_o.func = F_ROL; dec_o.bsrc = SRC_IMM5; end
      default:    dec_o.func = F_ADD;
    endcase
  end

endmodule

// File: rtl/alu_immext.sv
module alu_immext
  import alu_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int IMM_W  = 16
) (
  input  logic [IMM_W-1:0]  imm_i,
  input  ext_e              mode_i,
  output logic [DATA_W-1:0] ext_o
);

  localparam int PAD_W = DATA_W - IMM_W;

  always_comb begin
    unique case (mode_i)
      EXT_ZERO: ext_o = {{PAD_W{1'b0}}, imm_i};
      EXT_HIGH: ext_o = {imm_i, {PAD_W{1'b0}}};
      default:  ext_o = {{PAD_W{imm_i[IMM_W-1]}}, imm_i};
    endcase
  end

endmodule

// File: rtl/alu_datapath.sv
module alu_datapath
  import alu_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int SH_W   = $clog2(DATA_W)
) (
  input  func_e             func_i,
  input  logic [DATA_W-1:0] a_i,
  input  logic [DATA_W-1:0] b_i,
  output logic [DATA_W-1:0] res_o
);

  localparam int PROD_W = 2 * DATA_W;
  localparam logic [SH_W:0] WIDTH_C = DATA_W[SH_W:0];

  logic [SH_W-1:0]   sh;
  logic [SH_W:0]     sh_inv;
  logic              lt_s, lt_u, eq;
  logic              a_sgn, b_sgn;
  logic [PROD_W-1:0] ax, bx, prod;

  // Amount masked to the low bits of b for both register and imm5 forms.
  assign sh     = b_i[SH_W-1:0];
  assign sh_inv = WIDTH_C - {1'b0, sh};

  assign lt_s = $signed(a_i) < $signed(b_i);
  assign lt_u = a_i < b_i;
  assign eq   = a_i == b_i;

  // One shared multiplier; operand extension picks the signedness.
  assign a_sgn = (func_i == F_MHSS) || (func_i == F_MHSU);
  assign b_sgn = (func_i == F_MHSS);
  assign ax    = {{DATA_W{a_sgn & a_i[DATA_W-1]}}, a_i};
  assign bx    = {{DATA_W{b_sgn & b_i[DATA_W-1]}}, b_i};
  assign prod  = ax * bx;

  function automatic logic [DATA_W-1:0] flag(input logic f);
    return {{(DATA_W-1){1'b0}}, f};
  endfunction

  always_comb begin
    unique case (func_i)
      F_ADD:  res_o = a_i + b_i;
      F_SUB:  res_o = a_i - b_i;
      F_AND:  res_o = a_i & b_i;
      F_OR:   res_o = a_i | b_i;
      F_XOR:  res_o = a_i ^ b_i;
      F_NOR:  res_o = ~(a_i | b_i);
      F_GE:   res_o = flag(!lt_s);
      F_LT:   res_o = flag(lt_s);
      F_NE:   res_o = flag(!eq);
      F_EQ:   res_o = flag(eq);
      F_GEU:  res_o = flag(!lt_u);
      F_LTU:  res_o = flag(lt_u);
      F_SRA:  res_o = $unsigned($signed(a_i) >>> sh);
      F_SRL:  res_o = a_i >> sh;
      F_SLL:  res_o = a_i << sh;
      F_ROL:  res_o = (a_i << sh) | (a_i >> sh_inv);
      F_ROR:  res_o = (a_i >> sh) | (a_i << sh_inv);
      F_MUL:  res_o = prod[DATA_W-1:0];
      F_MHSS, F_MHUU, F_MHSU: res_o = prod[PROD_W-1:DATA_W];
      default: res_o = '0;
    endcase
  end

endmodule

// File: rtl/alu_exec.sv
module alu_exec
  import alu_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int IMM_W  = 16,
  parameter int SH_W   = $clog2(DATA_W),
  parameter int IDX_W  = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              valid_in,
  input  logic [OP_W-1:0]   op,
  input  logic [DATA_W-1:0] a,
  input  logic [DATA_W-1:0] b,
  input  logic [IMM_W-1:0]  imm16,
  input  logic [SH_W-1:0]   imm5,
  input  logic [IDX_W-1:0]  dest,
  output logic              valid_out,
  output logic [DATA_W-1:0] result,
  output logic              wr_en
);

  dec_t              dec;
  logic [DATA_W-1:0] imm_ext;
  logic [DATA_W-1:0] opb;
  logic [DATA_W-1:0] res_c;

  logic              valid_d, valid_q;
  logic              wr_d, wr_q;
  logic [DATA_W-1:0] res_d, res_q;

  alu_opdec u_dec (
    .op_i  (op),
    .dec_o (dec)
  );

  alu_immext #(.DATA_W(DATA_W), .IMM_W(IMM_W)) u_ext (
    .imm_i  (imm16),
    .mode_i (dec.ext),
    .ext_o  (imm_ext)
  );

  always_comb begin
    unique case (dec.bsrc)
      SRC_IMM16: opb = imm_ext;
      SRC_IMM5:  opb = {{(DATA_W-SH_W){1'b0}}, imm5};
      default:   opb = b;
    endcase
  end

  alu_datapath #(.DATA_W(DATA_W), .SH_W(SH_W)) u_dp (
    .func_i (dec.func),
    .a_i    (a),
    .b_i    (opb),
    .res_o  (res_c)
  );

  // Next state: result register is clock-enabled by valid_in.
  always_comb begin
    valid_d = valid_in;
    wr_d    = valid_in && (dest != '0);
    res_d   = valid_in ? res_c : res_q;
  end

  // rst_n is asserted asynchronously and released synchronously upstream.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid_q <= 1'b0;
      wr_q    <= 1'b0;
      res_q   <= '0;
    end else begin
      valid_q <= valid_d;
      wr_q    <= wr_d;
      res_q   <= res_d;
    end
  end

  assign valid_out = valid_q;
  assign wr_en     = wr_q;
  assign result    = res_q;

endmodule

// File: rtl/alu_exec_chk.sv
module alu_exec_chk
  import alu_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int SH_W   = 5,
  parameter int IDX_W  = 5
) (
  input logic              clk,
  input logic              rst_n,
  input logic              valid_in,
  input logic [OP_W-1:0]   op,
  input logic [DATA_W-1:0] a,
  input logic [DATA_W-1:0] b,
  input logic [IDX_W-1:0]  dest,
  input logic              valid_out,
  input logic [DATA_W-1:0] result,
  input logic              wr_en
);

  logic is_cmp;
  assign is_cmp = (op >= OP_W'(OP_CMPGE)  && op <= OP_W'(OP_CMPLTU)) ||
                  (op >= OP_W'(OP_CMPGEI) && op <= OP_W'(OP_CMPLTUI));

  // R9
  valid_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    valid_in |=> valid_out);

  // R9
  idle_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !valid_in |=> !valid_out);

  // R9
  result_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !valid_in |=> $stable(result));

  // R8
  zero_dest_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (valid_in && dest == '0) |=> !wr_en);

  // R8
  write_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |-> valid_out);

  // R2
  cmp_bool_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (valid_in && is_cmp) |=> (result[DATA_W-1:1] == '0));

  // R4
  shift_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (valid_in && op == OP_W'(OP_SLL) && b[SH_W-1:0] == '0) |=> (result == $past(a)));

  // R10
  always_comb begin
    if (!rst_n) begin
      reset_clear_chk: assert (valid_out == 1'b0 && wr_en == 1'b0);
    end
  end

endmodule

bind alu_exec alu_exec_chk #(.DATA_W(DATA_W), .SH_W(SH_W), .IDX_W(IDX_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .valid_in  (valid_in),
  .op        (op),
  .a         (a),
  .b         (b),
  .dest      (dest),
  .valid_out (valid_out),
  .result    (result),
  .wr_en     (wr_en)
);

// File: tb/alu_exec_tb_top.sv
`timescale 1ns/1ps
module alu_exec_tb_top;
  import alu_pkg::*;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        valid_in;
  logic [5:0]  op;
  logic [31:0] a, b;
  logic [15:0] imm16;
  logic [4:0]  imm5;
  logic [4:0]  dest;
  logic        valid_out;
  logic [31:0] result;
  logic        wr_en;

  int n_chk  = 0;
  int n_fail = 0;
  bit done   = 1'b0;

  always #2.5 clk = ~clk;

  alu_exec dut_i (
    .clk(clk), .rst_n(rst_n), .valid_in(valid_in), .op(op), .a(a), .b(b),
    .imm16(imm16), .imm5(imm5), .dest(dest), .valid_out(valid_out),
    .result(result), .wr_en(wr_en)
  );

  localparam logic [31:0] AV [8] = '{32'h0, 32'h1, 32'hFFFFFFFF, 32'h80000000,
                                     32'h7FFFFFFF, 32'h12345678, 32'hDEADBEEF, 32'h20};
  localparam logic [31:0] BV [8] = '{32'h0, 32'h1, 32'hFFFFFFFF, 32'h80000000,
                                     32'h7FFFFFE1, 32'h25, 32'hFFFFFFE0, 32'h1F};
  localparam logic [15:0] IV [8] = '{16'h0000, 16'h0001, 16'hFFFF, 16'h8000,
                                     16'h7FFF, 16'h1234, 16'hF00F, 16'h00FF};

  function automatic logic [31:0] rotl(input logic [31:0] x, input int n);
    logic [31:0] y = x;
    for (int k = 0; k < n; k++) y = {y[30:0], y[31]};
    return y;
  endfunction

  function automatic logic [31:0] bit01(input bit c);
    return c ? 32'd1 : 32'd0;
  endfunction

  function automatic logic [31:0] model(input int o, input logic [31:0] x,
                                        input logic [31:0] y, input logic [15:0] i16,
                                        input logic [4:0] i5);
    logic [31:0] sx = {{16{i16[15]}}, i16};
    logic [31:0] zx = {16'h0, i16};
    logic [31:0] hx = {i16, 16'h0};
    int          s  = int'(y % 32);
    longint      px;
    case (o)
      0:  return x + y;
      1:  return x - y;
      2:  return x & y;
      3:  return x | y;
      4:  return x ^ y;
      5:  return ~(x | y);
      6:  return bit01($signed(x) >= $signed(y));
      7:  return bit01($signed(x) <  $signed(y));
      8:  return bit01(x != y);
      9:  return bit01(x == y);
      10: return bit01(x >= y);
      11: return bit01(x <  y);
      12: return 32'(longint'($signed(x)) / (longint'(1) << s)) -
                 ((x[31] && (x % (32'd1 << s)) != 0) ? 32'd1 : 32'd0);
      13: return 32'(longint'({32'h0, x}) / (longint'(1) << s));
      14: return 32'(longint'({32'h0, x}) * (longint'(1) << s));
      15: return rotl(x, s);
      16: return rotl(x, (32 - s) % 32);
      17: return 32'(longint'({32'h0, x}) * longint'({32'h0, y}));
      18: begin px = longint'($signed(x)) * longint'($signed(y)); return px[63:32]; end
      19: begin px = longint'({32'h0, x}) * longint'({32'h0, y}); return px[63:32]; end
      20: begin px = longint'($signed(x)) * longint'({32'h0, y}); return px[63:32]; end
      21: return x + sx;
      22: return 32'(longint'({32'h0, x}) * longint'({32'h0, sx}));
      23: return x & zx;
      24: return x | zx;
      25: return x ^ zx;
      26: return x & hx;
      27: return x | hx;
      28: return x ^ hx;
      29: return bit01($signed(x) >= $signed(sx));
      30: return bit01($signed(x) <  $signed(sx));
      31: return bit01(x != sx);
      32: return bit01(x == sx);
      33: return bit01(x >= zx);
      34: return bit01(x <  zx);
      35: return model(12, x, {27'h0, i5}, i16, i5);
      36: return model(13, x, {27'h0, i5}, i16, i5);
      37: return model(14, x, {27'h0, i5}, i16, i5);
      38: return rotl(x, int'(i5));
      default: return 32'h0;
    endcase
  endfunction

  function automatic string tag(input int o);
    if (o <= 5)                           return "R1";
    if ((o >= 6 && o <= 11) || (o >= 31 && o <= 32)) return "R2";
    if (o >= 12 && o <= 16)               return "R4";
    if (o == 17)                          return "R6";
    if (o >= 18 && o <= 20)               return "R7";
    if (o >= 35)                          return "R5";
    return "R3";
  endfunction

  task automatic chk(input bit ok, input string t, input logic [31:0] got,
                     input logic [31:0] exp, input int o);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s op=%0d a=%h b=%h imm16=%h imm5=%0d: got %h expected %h",
               t, o, a, b, imm16, imm5, got, exp);
    end
  endtask

  initial begin
    #750000;
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    logic [31:0] exp, last;
    int          cnt = 0;
    rst_n = 1'b0; valid_in = 1'b0; op = '0; a = '0; b = '0;
    imm16 = '0; imm5 = '0; dest = '0;
    repeat (3) @(negedge clk);
    // R10: reset state
    chk(valid_out == 1'b0, "R10", {31'h0, valid_out}, 32'h0, 0);
    chk(wr_en == 1'b0,     "R10", {31'h0, wr_en},     32'h0, 0);
    chk(result == 32'h0,   "R10", result,             32'h0, 0);
    rst_n = 1'b1;
    @(negedge clk);

    for (int o = 0; o < OP_COUNT; o++) begin
      for (int ia = 0; ia < 8; ia++) begin
        for (int ib = 0; ib < 8; ib++) begin
          valid_in = 1'b1;
          op       = 6'(o);
          a        = AV[ia];
          b        = BV[ib];
          imm16    = IV[ib];
          imm5     = 5'((ib * 7 + 3) % 32);
          dest     = 5'(cnt % 32);
          cnt++;
          exp = model(o, a, b, imm16, imm5);
          @(negedge clk);
          chk(result == exp, tag(o), result, exp, o);
          // R9: one-cycle latency
          chk(valid_out == 1'b1, "R9", {31'h0, valid_out}, 32'h1, o);
          // R8: no write to index 0
          chk(wr_en == (dest != 5'd0), "R8", {31'h0, wr_en}, bit01(dest != 5'd0), o);
        end
      end
      // R9: idle cycle holds the result, no valid, no write
      last     = result;
      valid_in = 1'b0;
      a        = ~a;
      b        = ~b;
      dest     = 5'd7;
      @(negedge clk);
      chk(valid_out == 1'b0, "R9", {31'h0, valid_out}, 32'h0, o);
      chk(wr_en == 1'b0,     "R8", {31'h0, wr_en},     32'h0, o);
      chk(result == last,    "R9", result,             last,  o);
    end

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

endmodule